// File: doc/BRIEF.md
# System Exception Pending and Status Registers

This block is the software-facing register front end for the fixed system exceptions of a nested interrupt controller. It keeps a pending bit and an active bit for each of the sixteen system vectors. It keeps enable bits for the three fault handlers and an 8-bit priority slot for each of the system vectors 4 to 15. Software reaches this state through a small word-addressed register window. Hardware reaches it through a set-pending bus from peripherals and through take/complete strobes from the exception sequencer.

The numbering follows one fixed rule: system exceptions own vectors 0 to 15, and external interrupt n is vector 16+n. The control-state register combines the active vector and the pending vector, both supplied from outside, with the nesting flag and the any-external-pending flag. Software can set and clear the pendable-service and tick requests through it, and can set the NMI request. A set and a clear in the same write resolve in favour of the set. The window also holds the vector-table base, a keyed reset-request register, and a software trigger that forwards a bounded external interrupt number to the external interrupt logic.

Priority arbitration and exception entry belong to other blocks. This block only stores state and makes it visible.

Top module: `exc_status_regs`

## Requirements
- R1: After reset all pending bits, active bits, fault enables, priority slots and the vector-table base are zero, and neither the trigger pulse nor the reset request is asserted.
- R2: A read at offset 0xD04 returns the active vector (0 meaning none) in bits 8:0. Bit 11 is set when the active vector is 0 or when the active-nested input is low.
- R3: A read at 0xD04 returns the highest pending vector input in bits 20:12. Bit 22 is set when any bit of the external pending input is set.
- R4: A read at 0xD04 shows tick pending (vector 15) in bit 26, service pending (vector 14) in bit 28 and NMI pending (vector 2) in bit 31. A write to 0xD04 works as follows:
  - bit 31 sets NMI pending;
  - bit 28 sets service pending, and otherwise bit 27 clears it;
  - bit 26 sets tick pending, and otherwise bit 25 clears it.
- R5: In the same clock, a hardware set-pending request or a software set wins over a software clear or a take of that vector. A take moves a vector from pending to active. A complete clears active, unless a take of the same vector arrives in the same clock.
- R6: A read at 0xD24 returns these bits:
  - active bits at 0, 1, 3, 7, 8, 10 and 11, for vectors 4, 5, 6, 11, 12, 14 and 15;
  - pending bits at 12, 13, 14 and 15, for vectors 6, 4, 5 and 11;
  - fault enables at 16, 17 and 18, for vectors 4, 5 and 6.
  A write to 0xD24 changes only the enables.
- R7: The words at 0xD18, 0xD1C and 0xD20 each pack four 8-bit priorities, lowest vector in bits 7:0. The word at 0xD18 starts at vector 4. Only the top PRIO_W bits of each byte are stored.
- R8: A write at 0xF00 asserts the trigger for one clock with interrupt number wdata[8:0], but only when that number is below NUM_EXT. Otherwise the write is ignored.
- R9: A write at 0xD0C with wdata[31:16] = 0x05FA and bit 2 or bit 0 set asserts the reset request for one clock. Any other key does nothing. Reads at 0xD0C return 0xFA050000.
- R10: A write at 0xD08 stores wdata with bits 6:0 forced to zero, and a read returns the stored value.
- R11: Reads at any other offset return zero, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 12 | Byte offset of the register in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| act_vec | input | 9 | Currently active vector, 0 when none |
| act_nested | input | 1 | High when a preempted exception lies below the active one |
| pend_vec | input | 9 | Highest pending vector, 0 when none |
| ext_pend | input | NUM_EXT | Pending state of the external interrupts |
| hw_set_pend | input | 16 | Per-vector set-pending requests from hardware |
| take_valid | input | 1 | A system exception is being entered |
| take_vec | input | 4 | Vector being entered |
| done_valid | input | 1 | A system exception is being completed |
| done_vec | input | 4 | Vector being completed |
| sys_pend | output | 16 | Pending bits of the system vectors |
| sys_act | output | 16 | Active bits of the system vectors |
| fault_en | output | 3 | Enables for vectors 4, 5, 6 |
| sys_prio | output | 96 | Priorities of vectors 4..15, one byte each, vector 4 lowest |
| vtor | output | 32 | Vector-table base |
| trig_valid | output | 1 | Software trigger pulse |
| trig_irq | output | 9 | External interrupt number of the trigger |
| reset_req | output | 1 | Keyed reset request pulse |

## Verification
The hardest case to reach from the ports is a collision in a single clock. It happens when a set and a clear for one pendable vector arrive together, or when a hardware set lands in the same clock as the take of that vector. Either can arrive through a software write or through the hardware strobes. The directed part of the stimulus lines these events up on purpose: a register write carrying both the set bit and the clear bit, and a take driven together with a set-pending of the same vector. A long stretch of random stimulus then mixes writes, takes, completes and hardware sets, so collisions on every vector recur many times. A reference model in the bench is compared against every output on every clock.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;
  localparam int SYS_N    = 16;
  localparam int VEC_W    = 9;
  localparam int OFS_W    = 12;
  localparam int PSLOT_N  = 12;
  localparam int FAULT_N  = 3;

  localparam int EXC_NMI   = 2;
  localparam int EXC_MEM   = 4;
  localparam int EXC_BUS   = 5;
  localparam int EXC_USAGE = 6;
  localparam int EXC_SVC   = 11;
  localparam int EXC_DBG   = 12;
  localparam int EXC_SVCP  = 14;
  localparam int EXC_TICK  = 15;

  localparam logic [15:0] KEY_WRITE = 16'h05FA;
  localparam logic [15:0] KEY_READ  = 16'hFA05;

  localparam logic [OFS_W-1:0] OFS_CTRLST = 12'hD04;
  localparam logic [OFS_W-1:0] OFS_VBASE  = 12'hD08;
  localparam logic [OFS_W-1:0] OFS_KEYRST = 12'hD0C;
  localparam logic [OFS_W-1:0] OFS_PRIO0  = 12'hD18;
  localparam logic [OFS_W-1:0] OFS_PRIO1  = 12'hD1C;
  localparam logic [OFS_W-1:0] OFS_PRIO2  = 12'hD20;
  localparam logic [OFS_W-1:0] OFS_HSTAT  = 12'hD24;
  localparam logic [OFS_W-1:0] OFS_SWTRIG = 12'hF00;

  // Control-state read composition
  function automatic logic [31:0] ctrlst_compose(
    input logic [VEC_W-1:0] act, input logic nested,
    input logic [VEC_W-1:0] pv, input logic ext_any,
    input logic [SYS_N-1:0] pend);
    logic [31:0] r;
    r        = '0;
    r[8:0]   = act;
    r[11]    = (act == '0) || !nested;
    r[20:12] = pv;
    r[22]    = ext_any;
    r[26]    = pend[EXC_TICK];
    r[28]    = pend[EXC_SVCP];
    r[31]    = pend[EXC_NMI];
    return r;
  endfunction

  // Software set mask carried by a control-state write
  function automatic logic [SYS_N-1:0] ctrlst_set(input logic [31:0] w);
    logic [SYS_N-1:0] m;
    m           = '0;
    m[EXC_NMI]  = w[31];
    m[EXC_SVCP] = w[28];
    m[EXC_TICK] = w[26];
    return m;
  endfunction

  // Software clear mask carried by a control-state write
  function automatic logic [SYS_N-1:0] ctrlst_clr(input logic [31:0] w);
    logic [SYS_N-1:0] m;
    m           = '0;
    m[EXC_SVCP] = w[27] && !w[28];
    m[EXC_TICK] = w[25] && !w[26];
    return m;
  endfunction

  // Handler-status read composition
  function automatic logic [31:0] hstat_compose(
    input logic [SYS_N-1:0] pend, input logic [SYS_N-1:0] act,
    input logic [FAULT_N-1:0] en);
    logic [31:0] r;
    r      = '0;
    r[0]   = act[EXC_MEM];
    r[1]   = act[EXC_BUS];
    r[3]   = act[EXC_USAGE];
    r[7]   = act[EXC_SVC];
    r[8]   = act[EXC_DBG];
    r[10]  = act[EXC_SVCP];
    r[11]  = act[EXC_TICK];
    r[12]  = pend[EXC_USAGE];
    r[13]  = pend[EXC_MEM];
    r[14]  = pend[EXC_BUS];
    r[15]  = pend[EXC_SVC];
    r[18:16] = en;
    return r;
  endfunction
endpackage

// File: rtl/exc_pend_act.sv
module exc_pend_act #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_req,
  input  logic [N-1:0]     clr_req,
  input  logic             take_valid,
  input  logic [IDX_W-1:0] take_vec,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_vec,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     act
);
  logic [N-1:0] take_hit;
  logic [N-1:0] done_hit;
  logic [N-1:0] pend_q;
  logic [N-1:0] act_q;

  for (genvar i = 0; i < N; i++) begin : g_vec
    assign take_hit[i] = take_valid && (take_vec == IDX_W'(i));
    assign done_hit[i] = done_valid && (done_vec == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
      end else begin
        pend_q[i] <= set_req[i] | (pend_q[i] & ~(clr_req[i] | take_hit[i]));
        act_q[i]  <= take_hit[i] | (act_q[i] & ~done_hit[i]);
      end
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[i] |=> pend_q[i]);
    p_take_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hit[i] && !set_req[i]) |=> (act_q[i] && !pend_q[i]));
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_hit[i] && !take_hit[i]) |=> !act_q[i]);
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req[i] && !clr_req[i] && !take_hit[i]) |=> $stable(pend_q[i]));
  end

  assign pend = pend_q;
  assign act  = act_q;
endmodule

// File: rtl/exc_prio_bank.sv
module exc_prio_bank #(
  parameter int N_SLOTS = 12,
  parameter int PRIO_W  = 8,
  localparam int WORDS  = N_SLOTS / 4,
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LOW_W  = 8 - PRIO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WSEL_W-1:0]    wr_word,
  input  logic [31:0]          wdata,
  output logic [N_SLOTS*8-1:0] slot_prio
);
  logic [N_SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [PRIO_W-1:0] prio_q;
    assign slot_hit[s] = wr_en && (wr_word == WSEL_W'(s / 4));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           prio_q <= '0;
      else if (slot_hit[s]) prio_q <= wdata[(s % 4) * 8 + 7 -: PRIO_W];
    end

    if (LOW_W == 0) begin : g_full
      assign slot_prio[s*8 +: 8] = prio_q;
    end else begin : g_part
      assign slot_prio[s*8 +: 8] = {prio_q, {LOW_W{1'b0}}};
    end

    p_prio_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit[s] |=> slot_prio[s*8 + 7 -: PRIO_W] == $past(wdata[(s % 4) * 8 + 7 -: PRIO_W]));
    p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_hit[s] |=> $stable(slot_prio[s*8 +: 8]));
  end
endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs #(
  parameter int NUM_EXT = 64,
  localparam logic [9:0] EXT_LIMIT = 10'(NUM_EXT)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_vbase,
  input  logic        wr_keyrst,
  input  logic        wr_swtrig,
  input  logic [31:0] wdata,
  output logic [31:0] vtor,
  output logic        trig_valid,
  output logic [8:0]  trig_irq,
  output logic        reset_req
);
  import exc_regs_pkg::*;

  logic        trig_ok;
  logic        key_ok;
  logic        rst_hit;
  logic [31:0] vtor_q;

  assign trig_ok = wr_swtrig && ({1'b0, wdata[8:0]} < EXT_LIMIT);
  assign key_ok  = (wdata[31:16] == KEY_WRITE);
  assign rst_hit = wr_keyrst && key_ok && (wdata[2] || wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtor_q     <= '0;
      trig_valid <= 1'b0;
      trig_irq   <= '0;
      reset_req  <= 1'b0;
    end else begin
      if (wr_vbase) vtor_q <= {wdata[31:7], 7'b0};
      trig_valid <= trig_ok;
      if (trig_ok) trig_irq <= wdata[8:0];
      reset_req  <= rst_hit;
    end
  end

  assign vtor = vtor_q;

  p_vbase_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vbase |=> (vtor[31:7] == $past(wdata[31:7])) && (vtor[6:0] == 7'b0));
  p_vbase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vbase |=> $stable(vtor));
  p_trig_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> ({1'b0, trig_irq} < EXT_LIMIT));
  p_trig_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !wr_swtrig) |=> !trig_valid);
  p_key_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_keyrst && (wdata[31:16] != KEY_WRITE)) |=> !reset_req);
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs #(
  parameter int NUM_EXT = 64,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [8:0]         act_vec,
  input  logic               act_nested,
  input  logic [8:0]         pend_vec,
  input  logic [NUM_EXT-1:0] ext_pend,
  input  logic [15:0]        hw_set_pend,
  input  logic               take_valid,
  input  logic [3:0]         take_vec,
  input  logic               done_valid,
  input  logic [3:0]         done_vec,
  output logic [15:0]        sys_pend,
  output logic [15:0]        sys_act,
  output logic [2:0]         fault_en,
  output logic [95:0]        sys_prio,
  output logic [31:0]        vtor,
  output logic               trig_valid,
  output logic [8:0]         trig_irq,
  output logic               reset_req
);
  import exc_regs_pkg::*;

  localparam int WORDS = PSLOT_N / 4;

  // Write decode, brought out as named events
  logic wr_ctrlst, wr_vbase, wr_keyrst, wr_hstat, wr_swtrig, wr_prio;
  logic [1:0] prio_word;

  assign wr_ctrlst = bus_wr && (bus_addr == OFS_CTRLST);
  assign wr_vbase  = bus_wr && (bus_addr == OFS_VBASE);
  assign wr_keyrst = bus_wr && (bus_addr == OFS_KEYRST);
  assign wr_hstat  = bus_wr && (bus_addr == OFS_HSTAT);
  assign wr_swtrig = bus_wr && (bus_addr == OFS_SWTRIG);

  always_comb begin
    wr_prio   = 1'b0;
    prio_word = 2'd0;
    unique case (bus_addr)
      OFS_PRIO0: begin wr_prio = bus_wr; prio_word = 2'd0; end
      OFS_PRIO1: begin wr_prio = bus_wr; prio_word = 2'd1; end
      OFS_PRIO2: begin wr_prio = bus_wr; prio_word = 2'd2; end
      default: ;
    endcase
  end

  logic [SYS_N-1:0] sw_set, sw_clr, set_req;
  assign sw_set  = wr_ctrlst ? ctrlst_set(bus_wdata) : '0;
  assign sw_clr  = wr_ctrlst ? ctrlst_clr(bus_wdata) : '0;
  assign set_req = hw_set_pend | sw_set;

  exc_pend_act #(.N(SYS_N)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_req(set_req), .clr_req(sw_clr),
    .take_valid(take_valid), .take_vec(take_vec),
    .done_valid(done_valid), .done_vec(done_vec),
    .pend(sys_pend), .act(sys_act)
  );

  exc_prio_bank #(.N_SLOTS(PSLOT_N), .PRIO_W(PRIO_W)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_prio), .wr_word(prio_word), .wdata(bus_wdata),
    .slot_prio(sys_prio)
  );

  exc_ctl_regs #(.NUM_EXT(NUM_EXT)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_vbase(wr_vbase), .wr_keyrst(wr_keyrst), .wr_swtrig(wr_swtrig),
    .wdata(bus_wdata),
    .vtor(vtor), .trig_valid(trig_valid), .trig_irq(trig_irq),
    .reset_req(reset_req)
  );

  logic [FAULT_N-1:0] fault_en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_en_q <= '0;
    else if (wr_hstat) fault_en_q <= bus_wdata[18:16];
  end
  assign fault_en = fault_en_q;

  // Read path
  logic [31:0] prio_rd [WORDS];
  for (genvar w = 0; w < WORDS; w++) begin : g_rword
    assign prio_rd[w] = sys_prio[w*32 +: 32];
  end

  logic ext_any;
  assign ext_any = |ext_pend;

  always_comb begin
    unique case (bus_addr)
      OFS_CTRLST: bus_rdata = ctrlst_compose(act_vec, act_nested, pend_vec, ext_any, sys_pend);
      OFS_VBASE:  bus_rdata = vtor;
      OFS_KEYRST: bus_rdata = {KEY_READ, 16'h0000};
      OFS_PRIO0:  bus_rdata = prio_rd[0];
      OFS_PRIO1:  bus_rdata = prio_rd[1];
      OFS_PRIO2:  bus_rdata = prio_rd[2];
      OFS_HSTAT:  bus_rdata = hstat_compose(sys_pend, sys_act, fault_en_q);
      default:    bus_rdata = '0;
    endcase
  end

  logic addr_mapped;
  assign addr_mapped = (bus_addr == OFS_CTRLST) || (bus_addr == OFS_VBASE) ||
                       (bus_addr == OFS_KEYRST) || (bus_addr == OFS_PRIO0) ||
                       (bus_addr == OFS_PRIO1)  || (bus_addr == OFS_PRIO2) ||
                       (bus_addr == OFS_HSTAT);

  p_idle_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRLST && act_vec == '0) |-> (bus_rdata[8:0] == '0 && bus_rdata[11]));
  p_key_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_KEYRST) |-> (bus_rdata == 32'hFA05_0000));
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (bus_rdata == '0));
  p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hstat |=> (fault_en == $past(bus_wdata[18:16])));
  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hstat |=> $stable(fault_en));
endmodule

// File: tb/exc_status_regs_tb.sv
module exc_status_regs_tb_top;
  localparam int NUM_EXT = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_wr = 1'b0;
  logic [11:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [8:0]         act_vec = '0;
  logic               act_nested = 1'b0;
  logic [8:0]         pend_vec = '0;
  logic [NUM_EXT-1:0] ext_pend = '0;
  logic [15:0]        hw_set_pend = '0;
  logic               take_valid = 1'b0;
  logic [3:0]         take_vec = '0;
  logic               done_valid = 1'b0;
  logic [3:0]         done_vec = '0;
  logic [15:0]        sys_pend, sys_act;
  logic [2:0]         fault_en;
  logic [95:0]        sys_prio;
  logic [31:0]        vtor;
  logic               trig_valid;
  logic [8:0]         trig_irq;
  logic               reset_req;

  exc_status_regs #(.NUM_EXT(NUM_EXT), .PRIO_W(8)) dut_i (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  logic [15:0] m_pend, m_act;
  logic [2:0]  m_en;
  logic [7:0]  m_prio [12];
  logic [31:0] m_vtor;
  logic        m_trig;
  logic [8:0]  m_trig_irq;
  logic        m_rst;

  task automatic chk(input bit ok, input string tag, input logic [95:0] got, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_act = '0; m_en = '0; m_vtor = '0;
    m_trig = 0; m_trig_irq = '0; m_rst = 0;
    for (int k = 0; k < 12; k++) m_prio[k] = '0;
  endtask

  task automatic model_update();
    logic [15:0] s, c;
    s = hw_set_pend;
    c = '0;
    if (bus_wr && bus_addr == 12'hD04) begin
      if (bus_wdata[31]) s[2] = 1;
      if (bus_wdata[28]) s[14] = 1; else if (bus_wdata[27]) c[14] = 1;
      if (bus_wdata[26]) s[15] = 1; else if (bus_wdata[25]) c[15] = 1;
    end
    if (take_valid) c[take_vec] = 1;
    m_pend = (m_pend & ~c) | s;
    for (int v = 0; v < 16; v++) begin
      if (take_valid && take_vec == 4'(v)) m_act[v] = 1;
      else if (done_valid && done_vec == 4'(v)) m_act[v] = 0;
    end
    m_trig = 0;
    m_rst  = 0;
    if (bus_wr) begin
      case (bus_addr)
        12'hD08: m_vtor = bus_wdata & 32'hFFFF_FF80;
        12'hD24: m_en = bus_wdata[18:16];
        12'hD18, 12'hD1C, 12'hD20: begin
          int base;
          base = (int'(bus_addr) - 'hD18);
          for (int b = 0; b < 4; b++) m_prio[base + b] = bus_wdata[b*8 +: 8];
        end
        12'hF00: if (int'(bus_wdata[8:0]) < NUM_EXT) begin
          m_trig = 1; m_trig_irq = bus_wdata[8:0];
        end
        12'hD0C: if (bus_wdata[31:16] == 16'h05FA && (bus_wdata[2] || bus_wdata[0])) m_rst = 1;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] v;
    int base;
    v = '0;
    case (a)
      12'hD04: begin
        v[8:0]   = act_vec;
        v[11]    = (act_vec == 0) || !act_nested;
        v[20:12] = pend_vec;
        v[22]    = (ext_pend != '0);
        v[26]    = m_pend[15];
        v[28]    = m_pend[14];
        v[31]    = m_pend[2];
      end
      12'hD08: v = m_vtor;
      12'hD0C: v = 32'hFA05_0000;
      12'hD18, 12'hD1C, 12'hD20: begin
        base = int'(a) - 'hD18;
        v = {m_prio[base+3], m_prio[base+2], m_prio[base+1], m_prio[base]};
      end
      12'hD24: begin
        v[0] = m_act[4];  v[1] = m_act[5];  v[3] = m_act[6];  v[7] = m_act[11];
        v[8] = m_act[12]; v[10] = m_act[14]; v[11] = m_act[15];
        v[12] = m_pend[6]; v[13] = m_pend[4]; v[14] = m_pend[5]; v[15] = m_pend[11];
        v[18:16] = m_en;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string addr_tag(input logic [11:0] a);
    case (a)
      12'hD04: return "R2/R3/R4 ctrl-state read";
      12'hD08: return "R10 vector base read";
      12'hD0C: return "R9 key register read";
      12'hD18, 12'hD1C, 12'hD20: return "R7 priority read";
      12'hD24: return "R6 handler status read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  task automatic compare_all();
    logic [95:0] pk;
    logic [31:0] er;
    for (int k = 0; k < 12; k++) pk[k*8 +: 8] = m_prio[k];
    er = exp_read(bus_addr);
    chk(bus_rdata === er, addr_tag(bus_addr), 96'(bus_rdata), 96'(er));
    chk(sys_pend === m_pend, "R5 pending bits", 96'(sys_pend), 96'(m_pend));
    chk(sys_act === m_act, "R5 active bits", 96'(sys_act), 96'(m_act));
    chk(fault_en === m_en, "R6 fault enables", 96'(fault_en), 96'(m_en));
    chk(sys_prio === pk, "R7 priority slots", sys_prio, pk);
    chk(vtor === m_vtor, "R10 vector base", 96'(vtor), 96'(m_vtor));
    chk(trig_valid === m_trig, "R8 trigger pulse", 96'(trig_valid), 96'(m_trig));
    if (m_trig) chk(trig_irq === m_trig_irq, "R8 trigger number", 96'(trig_irq), 96'(m_trig_irq));
    chk(reset_req === m_rst, "R9 reset request", 96'(reset_req), 96'(m_rst));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, 96'(bus_rdata), 96'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(sys_pend == 0 && sys_act == 0, "R1 reset pend/act", 96'({sys_pend, sys_act}), 96'(0));
    chk(!trig_valid && !reset_req, "R1 reset pulses", 96'({trig_valid, reset_req}), 96'(0));
    rd(12'hD08, 32'h0, "R1 vector base after reset");
    rd(12'hD24, 32'h0, "R1 handler status after reset");
    rd(12'hD18, 32'h0, "R1 priorities after reset");
    rd(12'hD0C, 32'hFA05_0000, "R9 key register read value");
    step();

    // R2 / R3 control-state composition
    rd(12'hD04, 32'h0000_0800, "R2 idle control state");
    act_vec = 9'd19; act_nested = 1;
    rd(12'hD04, 32'h0000_0013, "R2 active external vector with nesting");
    act_nested = 0;
    rd(12'hD04, 32'h0000_0813, "R2 active with nothing beneath");
    act_nested = 1; pend_vec = 9'd20;
    rd(12'hD04, 32'h0001_4013, "R3 pending vector field");
    ext_pend[5] = 1;
    rd(12'hD04, 32'h0041_4013, "R3 any external pending");
    act_vec = 0; act_nested = 0; pend_vec = 0; ext_pend = '0;
    step();

    // R4 software set/clear
    wr(12'hD04, 32'h9400_0000);
    rd(12'hD04, 32'h9400_0800, "R4 set nmi, service, tick");
    wr(12'hD04, 32'h1A00_0000);
    rd(12'hD04, 32'h9000_0800, "R4 set wins over clear, tick cleared");
    wr(12'hD04, 32'h0800_0000);
    rd(12'hD04, 32'h8000_0800, "R4 service cleared");

    // R5 hardware set, take, complete
    hw_set_pend = 16'h0010; step(); hw_set_pend = '0;
    rd(12'hD24, 32'h0000_2000, "R5 hardware set memory pending");
    take_valid = 1; take_vec = 4'd4; step(); take_valid = 0;
    rd(12'hD24, 32'h0000_0001, "R5 take moves pending to active");
    take_valid = 1; take_vec = 4'd11; hw_set_pend = 16'h0800; step();
    take_valid = 0; hw_set_pend = '0;
    rd(12'hD24, 32'h0000_8081, "R5 set wins over take");
    done_valid = 1; done_vec = 4'd4; step(); done_valid = 0;
    rd(12'hD24, 32'h0000_8080, "R5 complete clears active");

    // R6 only enables writable
    wr(12'hD24, 32'hFFFF_FFFF);
    rd(12'hD24, 32'h0007_8080, "R6 only enables change");
    chk(fault_en == 3'b111, "R6 fault enable output", 96'(fault_en), 96'(7));

    // R7 priorities
    wr(12'hD18, 32'h4433_2211);
    chk(sys_prio[7:0] == 8'h11, "R7 vector 4 in byte 0", 96'(sys_prio[7:0]), 96'(8'h11));
    rd(12'hD1C, 32'h0, "R7 neighbour word untouched");
    wr(12'hD20, 32'hF0E0_D0C0);
    chk(sys_prio[95:88] == 8'hF0, "R7 vector 15 top byte", 96'(sys_prio[95:88]), 96'(8'hF0));
    rd(12'hD20, 32'hF0E0_D0C0, "R7 word read back");

    // R8 software trigger
    wr(12'hF00, 32'h0000_0023);
    chk(trig_valid && trig_irq == 9'h23, "R8 trigger accepted", 96'({trig_valid, trig_irq}), 96'({1'b1, 9'h23}));
    step();
    chk(!trig_valid, "R8 trigger one clock", 96'(trig_valid), 96'(0));
    wr(12'hF00, 32'd64);
    chk(!trig_valid, "R8 number equal to limit ignored", 96'(trig_valid), 96'(0));
    wr(12'hF00, 32'h0000_0240);
    chk(!trig_valid, "R8 upper bits dropped, 64 ignored", 96'(trig_valid), 96'(0));
    wr(12'hF00, 32'h0000_003F);
    chk(trig_valid && trig_irq == 9'h3F, "R8 highest legal number", 96'({trig_valid, trig_irq}), 96'({1'b1, 9'h3F}));

    // R9 keyed reset
    wr(12'hD0C, 32'h05FA_0004);
    chk(reset_req, "R9 keyed reset request", 96'(reset_req), 96'(1));
    wr(12'hD0C, 32'h05FB_0004);
    chk(!reset_req, "R9 wrong key ignored", 96'(reset_req), 96'(0));
    wr(12'hD0C, 32'h05FA_0000);
    chk(!reset_req, "R9 key without request", 96'(reset_req), 96'(0));

    // R10 vector base
    wr(12'hD08, 32'h2000_01FF);
    rd(12'hD08, 32'h2000_0180, "R10 low bits masked");

    // R11 unmapped
    rd(12'hD10, 32'h0, "R11 unmapped read");
    rd(12'hD06, 32'h0, "R11 misaligned read");
    wr(12'hD28, 32'hFFFF_FFFF);
    rd(12'hD24, 32'h0007_8080, "R11 unmapped write leaves status");
    rd(12'hD08, 32'h2000_0180, "R11 unmapped write leaves base");

    // Random mix compared against the model every clock
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] alist [10];
      alist = '{12'hD04, 12'hD08, 12'hD0C, 12'hD18, 12'hD1C, 12'hD20, 12'hD24, 12'hF00, 12'hD10, 12'h004};
      bus_wr      = ($urandom % 3) == 0;
      bus_addr    = alist[$urandom % 10];
      bus_wdata   = $urandom;
      if (bus_addr == 12'hF00) bus_wdata[31:9] = '0;
      if (bus_addr == 12'hD0C && ($urandom % 2 == 0)) bus_wdata[31:16] = 16'h05FA;
      hw_set_pend = (($urandom % 4) == 0) ? 16'($urandom) : '0;
      take_valid  = ($urandom % 3) == 0;
      take_vec    = 4'($urandom);
      done_valid  = ($urandom % 3) == 0;
      done_vec    = 4'($urandom);
      act_vec     = 9'($urandom);
      act_nested  = 1'($urandom);
      pend_vec    = 9'($urandom);
      ext_pend    = (($urandom % 2) == 0) ? '0 : (NUM_EXT'(1) << ($urandom % NUM_EXT));
      step();
    end
    bus_wr = 0; take_valid = 0; done_valid = 0; hw_set_pend = '0;
    step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule